// File: doc/BRIEF.md
# Branch History Ring Recorder

This block keeps a circular history of taken branches. Each retired branch arrives on a strobe with its source address, its target address, a kind code, the privilege of its target and three status flags: mispredicted, executed inside a transaction, and aborted a transaction. A 10-bit select register decides which branches are kept. Most of its bits suppress one class of branch, so a cleared select register keeps everything. Accepted branches are written into a power-of-two ring, and a top pointer always names the newest record.

A second mode keeps a call stack. While it is on, calls push a record and near returns pop the newest one. The pointer then follows the depth of calls, and a reader stops at the first record whose from field is zero. The recorder can be turned off with a global enable. It can be frozen by a performance interrupt, but only outside call-stack mode. A clear operation wipes every record.

A read port takes a distance k and returns, in the same cycle, the record k places back from the newest one.

Top module: `brrec_ring`

## Requirements
- R1: After reset the top pointer is 0, every record reads as zero, the freeze flag is low and the select register is zero.
- R2: Outside call-stack mode, an accepted branch is written at index (top+1) mod DEPTH and the pointer advances to that index, wrapping from DEPTH-1 to 0, on the clock edge where the strobe is sampled.
- R3: The read port returns the record at index (top − rd_back) mod DEPTH combinationally, from the current state.
- R4: A stored from field holds the source address in bits ADDR_W-1:0, zeros above it up to bit 60, the transaction-abort flag in bit 61, the in-transaction flag in bit 62 and the mispredict flag in bit 63. A stored to field is the target address extended with zeros.
- R5: Select bit 0 drops branches whose target is privilege ring 0 (br_ring0=1). Select bit 1 drops branches whose target is any other ring (br_ring0=0).
- R6: Kind codes are 0 conditional, 1 relative call, 2 indirect call, 3 near return, 4 indirect jump, 5 relative jump, 6 far branch, and 7 is never recorded. Kind c is dropped when select bit c+2 is set. Select write bits above bit 9 are ignored.
- R7: With rec_en low no branch changes any record or the pointer.
- R8: A pmi pulse while frz_on_pmi is high and call-stack mode is off sets the freeze flag from the next cycle. While the flag is set, no branch is recorded. An unfreeze pulse clears it, and pmi wins when both pulses arrive in the same cycle. A branch in the pmi cycle itself is still recorded.
- R9: While call-stack mode (select bit 9) is on, pmi never sets the freeze flag.
- R10: In call-stack mode an accepted near return zeroes the record at the pointer and steps the pointer back, wrapping from 0 to DEPTH-1. Any other accepted kind pushes as in R2.
- R11: A clear pulse zeroes every from and to record and leaves the pointer unchanged. A branch in the same cycle is dropped.
- R12: A select write takes effect for branches from the next cycle. A branch presented in the same cycle as the write is filtered with the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rec_en | input | 1 | Global recording enable |
| frz_on_pmi | input | 1 | Allow a performance interrupt to freeze recording |
| pmi | input | 1 | Performance interrupt pulse |
| unfreeze | input | 1 | Clears the freeze flag |
| clear | input | 1 | Zeroes every record |
| sel_we | input | 1 | Select register write strobe |
| sel_wdata | input | SEL_IN_W | Select write data; only bits 9:0 are kept |
| br_valid | input | 1 | A retired taken branch is presented |
| br_from | input | ADDR_W | Branch source address |
| br_to | input | ADDR_W | Branch target address |
| br_kind | input | 3 | Branch kind code |
| br_ring0 | input | 1 | Target runs at privilege ring 0 |
| br_mispred | input | 1 | Branch was mispredicted |
| br_in_tx | input | 1 | Branch executed inside a transaction |
| br_abort | input | 1 | Branch is a transaction abort |
| rd_back | input | $clog2(DEPTH) | Distance back from the newest record |
| rd_from | output | REC_W | From field of the selected record |
| rd_to | output | REC_W | To field of the selected record |
| tos | output | $clog2(DEPTH) | Index of the newest record |
| frozen | output | 1 | Freeze flag |

## Verification
Record, pointer, clear and select-register effects land on the clock edge that samples the stimulus. The freeze flag also changes on that edge, so it gates branches only from the following cycle. The bench drives inputs on the falling edge, advances one rising edge, and compares on the next falling edge against a model updated from the pre-edge state. The read port is combinational, so the bench moves rd_back and compares after a short settle within the same low phase. The sweep covers every kind and privilege under each single suppress bit, and it includes pointer wrap in both directions.

// File: rtl/brrec_pkg.sv
package brrec_pkg;

    localparam int SEL_W         = 10;
    localparam int SEL_DROP_KERN = 0;
    localparam int SEL_DROP_USER = 1;
    localparam int SEL_KIND_BASE = 2;
    localparam int SEL_CSTACK    = 9;

    typedef enum logic [2:0] {
        BK_COND     = 3'd0,
        BK_REL_CALL = 3'd1,
        BK_IND_CALL = 3'd2,
        BK_NEAR_RET = 3'd3,
        BK_IND_JMP  = 3'd4,
        BK_REL_JMP  = 3'd5,
        BK_FAR      = 3'd6,
        BK_NONE     = 3'd7
    } br_kind_e;

    localparam int FLAG_ABORT_BIT = 61;
    localparam int FLAG_INTX_BIT  = 62;
    localparam int FLAG_MISP_BIT  = 63;

endpackage

// File: rtl/brrec_ctrl.sv
module brrec_ctrl
    import brrec_pkg::*;
#(
    parameter int SEL_IN_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_we_i,
    input  logic [SEL_IN_W-1:0] sel_wdata_i,
    input  logic                frz_on_pmi_i,
    input  logic                pmi_i,
    input  logic                unfreeze_i,
    output logic [SEL_W-1:0]    sel_o,
    output logic                cs_mode_o,
    output logic                frozen_o
);

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             frozen;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  cs_now;

    assign cs_now = c_q.sel[SEL_CSTACK];

    always_comb begin
        c_d = c_q;
        if (sel_we_i) begin
            c_d.sel = sel_wdata_i[SEL_W-1:0];
        end
        if (pmi_i && frz_on_pmi_i && !cs_now) begin
            c_d.frozen = 1'b1;
        end else if (unfreeze_i) begin
            c_d.frozen = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign sel_o     = c_q.sel;
    assign cs_mode_o = cs_now;
    assign frozen_o  = c_q.frozen;

    // R9: freeze only rises from an interrupt seen outside call-stack mode
    assert_no_cs_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.frozen) |-> $past(pmi_i && !cs_now));

    // R8: an unfreeze without an interrupt drops the flag
    assert_unfreeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (unfreeze_i && !pmi_i) |=> !c_q.frozen);

endmodule

// File: rtl/brrec_filter.sv
module brrec_filter
    import brrec_pkg::*;
(
    input  logic             valid_i,
    input  logic [2:0]       kind_i,
    input  logic             ring0_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             en_i,
    input  logic             frozen_i,
    input  logic             clr_i,
    output logic             push_o,
    output logic             pop_o
);

    logic [7:0] kind_drop;
    logic       priv_drop;
    logic       live;
    logic       keep;
    logic       is_ret;

    // kind code c maps onto select bit c+2; code 7 is always dropped
    assign kind_drop = {1'b1, sel_i[SEL_KIND_BASE +: 7]};
    assign priv_drop = ring0_i ? sel_i[SEL_DROP_KERN] : sel_i[SEL_DROP_USER];
    assign live      = valid_i && en_i && !frozen_i && !clr_i;
    assign keep      = live && !priv_drop && !kind_drop[kind_i];
    assign is_ret    = (kind_i == BK_NEAR_RET);

    assign pop_o  = keep && sel_i[SEL_CSTACK] && is_ret;
    assign push_o = keep && !(sel_i[SEL_CSTACK] && is_ret);

endmodule

// File: rtl/brrec_store.sv
module brrec_store #(
    parameter int DEPTH = 16,
    parameter int REC_W = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             clr_i,
    input  logic [REC_W-1:0] wfrom_i,
    input  logic [REC_W-1:0] wto_i,
    input  logic [IDX_W-1:0] rd_back_i,
    output logic [REC_W-1:0] rd_from_o,
    output logic [REC_W-1:0] rd_to_o,
    output logic [IDX_W-1:0] tos_o
);

    typedef struct packed {
        logic [DEPTH-1:0][REC_W-1:0] frm;
        logic [DEPTH-1:0][REC_W-1:0] to;
        logic [IDX_W-1:0]            tos;
    } ring_t;

    ring_t            s_d, s_q;
    logic [IDX_W-1:0] nxt_idx;
    logic [IDX_W-1:0] prv_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [DEPTH-1:0] wr_hit;
    logic [DEPTH-1:0] zap_hit;

    assign nxt_idx = s_q.tos + 1'b1;
    assign prv_idx = s_q.tos - 1'b1;

    // per-entry write and wipe decode
    for (genvar e = 0; e < DEPTH; e++) begin : g_dec
        assign wr_hit[e]  = push_i && !clr_i && (nxt_idx == IDX_W'(e));
        assign zap_hit[e] = clr_i || (pop_i && (s_q.tos == IDX_W'(e)));
    end

    always_comb begin
        s_d = s_q;
        for (int e = 0; e < DEPTH; e++) begin
            if (zap_hit[e]) begin
                s_d.frm[e] = '0;
                s_d.to[e]  = '0;
            end else if (wr_hit[e]) begin
                s_d.frm[e] = wfrom_i;
                s_d.to[e]  = wto_i;
            end
        end
        if (!clr_i) begin
            if (push_i) begin
                s_d.tos = nxt_idx;
            end else if (pop_i) begin
                s_d.tos = prv_idx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_idx    = s_q.tos - rd_back_i;
    assign rd_from_o = s_q.frm[rd_idx];
    assign rd_to_o   = s_q.to[rd_idx];
    assign tos_o     = s_q.tos;

    assert_push_adv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !clr_i) |=> s_q.tos == IDX_W'($past(s_q.tos) + 1'b1));

    assert_pop_back_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !clr_i) |=> (s_q.tos == IDX_W'($past(s_q.tos) - 1'b1))
                              && (s_q.frm[$past(s_q.tos)] == '0));

    assert_clear_all_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (s_q.frm == '0) && (s_q.to == '0) && $stable(s_q.tos));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !pop_i) |=> $stable(s_q.tos));

endmodule

// File: rtl/brrec_ring.sv
module brrec_ring
    import brrec_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int ADDR_W   = 48,
    parameter int REC_W    = 64,
    parameter int SEL_IN_W = 16,
    localparam int IDX_W   = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rec_en,
    input  logic                frz_on_pmi,
    input  logic                pmi,
    input  logic                unfreeze,
    input  logic                clear,
    input  logic                sel_we,
    input  logic [SEL_IN_W-1:0] sel_wdata,
    input  logic                br_valid,
    input  logic [ADDR_W-1:0]   br_from,
    input  logic [ADDR_W-1:0]   br_to,
    input  logic [2:0]          br_kind,
    input  logic                br_ring0,
    input  logic                br_mispred,
    input  logic                br_in_tx,
    input  logic                br_abort,
    input  logic [IDX_W-1:0]    rd_back,
    output logic [REC_W-1:0]    rd_from,
    output logic [REC_W-1:0]    rd_to,
    output logic [IDX_W-1:0]    tos,
    output logic                frozen
);

    localparam int PAD_W = FLAG_ABORT_BIT - ADDR_W;

    logic [SEL_W-1:0] sel;
    logic             cs_mode;
    logic             push;
    logic             pop;
    logic [REC_W-1:0] wfrom;
    logic [REC_W-1:0] wto;

    brrec_ctrl #(.SEL_IN_W(SEL_IN_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_we_i     (sel_we),
        .sel_wdata_i  (sel_wdata),
        .frz_on_pmi_i (frz_on_pmi),
        .pmi_i        (pmi),
        .unfreeze_i   (unfreeze),
        .sel_o        (sel),
        .cs_mode_o    (cs_mode),
        .frozen_o     (frozen)
    );

    brrec_filter u_filter (
        .valid_i  (br_valid),
        .kind_i   (br_kind),
        .ring0_i  (br_ring0),
        .sel_i    (sel),
        .en_i     (rec_en),
        .frozen_i (frozen),
        .clr_i    (clear),
        .push_o   (push),
        .pop_o    (pop)
    );

    // from field: flags on top, zero pad, then the source address
    always_comb begin
        wfrom = '0;
        wfrom[ADDR_W-1:0]     = br_from;
        wfrom[FLAG_ABORT_BIT] = br_abort;
        wfrom[FLAG_INTX_BIT]  = br_in_tx;
        wfrom[FLAG_MISP_BIT]  = br_mispred;
        wto   = '0;
        wto[ADDR_W-1:0]       = br_to;
    end

    brrec_store #(.DEPTH(DEPTH), .REC_W(REC_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (push),
        .pop_i     (pop),
        .clr_i     (clear),
        .wfrom_i   (wfrom),
        .wto_i     (wto),
        .rd_back_i (rd_back),
        .rd_from_o (rd_from),
        .rd_to_o   (rd_to),
        .tos_o     (tos)
    );

    assert_frozen_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |-> !(push || pop));

    assert_one_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));

    assert_pop_only_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> cs_mode);

    assert_enable_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_en |=> $stable(tos));

    initial begin
        assert_pad_fits_R4: assert (PAD_W >= 0 && REC_W == 64);
    end

endmodule

// File: tb/brrec_ring_bench.sv
module brrec_ring_bench;

    localparam int DEPTH = 16;
    localparam int AW    = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rec_en = 1'b0, frz_on_pmi = 1'b0, pmi = 1'b0, unfreeze = 1'b0;
    logic        clear = 1'b0, sel_we = 1'b0;
    logic [15:0] sel_wdata = '0;
    logic        br_valid = 1'b0;
    logic [AW-1:0] br_from = '0, br_to = '0;
    logic [2:0]  br_kind = '0;
    logic        br_ring0 = 1'b0, br_mispred = 1'b0, br_in_tx = 1'b0, br_abort = 1'b0;
    logic [3:0]  rd_back = '0;
    logic [63:0] rd_from, rd_to;
    logic [3:0]  tos;
    logic        frozen;

    int total = 0;
    int bad = 0;

    logic [63:0] mfrom [DEPTH];
    logic [63:0] mto   [DEPTH];
    logic [3:0]  mtos;
    logic [9:0]  msel;
    logic        mfrz;

    brrec_ring u_brrec_ring (
        .clk(clk), .rst_n(rst_n), .rec_en(rec_en), .frz_on_pmi(frz_on_pmi),
        .pmi(pmi), .unfreeze(unfreeze), .clear(clear), .sel_we(sel_we),
        .sel_wdata(sel_wdata), .br_valid(br_valid), .br_from(br_from),
        .br_to(br_to), .br_kind(br_kind), .br_ring0(br_ring0),
        .br_mispred(br_mispred), .br_in_tx(br_in_tx), .br_abort(br_abort),
        .rd_back(rd_back), .rd_from(rd_from), .rd_to(rd_to), .tos(tos),
        .frozen(frozen)
    );

    always #5 clk = ~clk;

    initial begin
        #1500000;
        total++;
        bad++;
        $display("FAIL watchdog: run did not complete");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // advance the model from the pre-edge inputs, then one clock edge
    task automatic tick();
        logic acc;
        logic cs;
        logic [63:0] f;
        logic [63:0] t;
        logic [3:0]  ni;
        cs  = msel[9];
        acc = br_valid && rec_en && !mfrz && !clear
              && !(br_ring0 ? msel[0] : msel[1])
              && (br_kind != 3'd7) && !msel[br_kind + 2];
        f = 64'(br_from);
        f[61] = br_abort; f[62] = br_in_tx; f[63] = br_mispred;
        t = 64'(br_to);
        if (clear) begin
            for (int i = 0; i < DEPTH; i++) begin mfrom[i] = '0; mto[i] = '0; end
        end else if (acc) begin
            if (cs && br_kind == 3'd3) begin
                mfrom[mtos] = '0; mto[mtos] = '0; mtos = mtos - 4'd1;
            end else begin
                ni = mtos + 4'd1;
                mfrom[ni] = f; mto[ni] = t; mtos = ni;
            end
        end
        if (pmi && frz_on_pmi && !cs) mfrz = 1'b1;
        else if (unfreeze) mfrz = 1'b0;
        if (sel_we) msel = sel_wdata[9:0];
        @(posedge clk);
        @(negedge clk);
        br_valid = 1'b0; pmi = 1'b0; unfreeze = 1'b0; clear = 1'b0; sel_we = 1'b0;
    endtask

    task automatic check_all(input string tag);
        for (int k = 0; k < DEPTH; k++) begin
            logic [3:0] ix;
            rd_back = 4'(k);
            ix = mtos - 4'(k);
            #1;
            chk(tag, rd_from, mfrom[ix]);
            chk(tag, rd_to, mto[ix]);
        end
        chk(tag, 64'(tos), 64'(mtos));
    endtask

    task automatic check_top(input string tag);
        rd_back = '0;
        #1;
        chk(tag, 64'(tos), 64'(mtos));
        chk(tag, rd_from, mfrom[mtos]);
        chk(tag, rd_to, mto[mtos]);
        chk(tag, 64'(frozen), 64'(mfrz));
    endtask

    task automatic branch(input logic [2:0] kind, input logic ring0, input int seed);
        br_valid   = 1'b1;
        br_kind    = kind;
        br_ring0   = ring0;
        br_from    = AW'(48'h8000_0000_1000 + seed * 48'h1_0137);
        br_to      = AW'(48'h0000_7fff_2000 + seed * 48'h2_0059);
        br_mispred = seed[0];
        br_in_tx   = seed[1];
        br_abort   = seed[2];
    endtask

    task automatic write_sel(input logic [15:0] v);
        sel_we = 1'b1;
        sel_wdata = v;
    endtask

    int seed = 0;

    initial begin
        for (int i = 0; i < DEPTH; i++) begin mfrom[i] = '0; mto[i] = '0; end
        mtos = '0; msel = '0; mfrz = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset state");
        chk("R1 reset freeze", 64'(frozen), 64'd0);

        rec_en = 1'b1;
        // sweep: every kind and privilege under each single suppress bit
        for (int s = 0; s <= 10; s++) begin
            if (s < 9) write_sel(16'(1 << s));
            else if (s == 9) write_sel(16'hFC00);  // upper bits ignored (R6)
            else write_sel(16'h0000);
            tick();
            for (int k = 0; k < 8; k++) begin
                for (int r = 0; r < 2; r++) begin
                    branch(3'(k), r[0], seed);
                    seed++;
                    tick();
                    check_top("R2,R4,R5,R6 sweep");
                end
            end
        end
        check_all("R3 readback after sweep");

        // R12: write in the same cycle as a conditional branch
        write_sel(16'h0004);
        branch(3'd0, 1'b0, seed++);
        tick();
        check_top("R12 old select used");
        branch(3'd0, 1'b0, seed++);
        tick();
        check_top("R12 new select used");
        write_sel(16'h0000);
        tick();

        // R7: disabled
        rec_en = 1'b0;
        branch(3'd1, 1'b1, seed++);
        tick();
        check_top("R7 disabled");
        rec_en = 1'b1;

        // R8: freeze on interrupt
        frz_on_pmi = 1'b1;
        pmi = 1'b1;
        branch(3'd2, 1'b0, seed++);
        tick();
        check_top("R8 pmi cycle recorded");
        branch(3'd4, 1'b0, seed++);
        tick();
        check_top("R8 frozen drops");
        pmi = 1'b1; unfreeze = 1'b1;
        tick();
        check_top("R8 pmi beats unfreeze");
        unfreeze = 1'b1;
        tick();
        check_top("R8 unfreeze");
        branch(3'd5, 1'b1, seed++);
        tick();
        check_top("R8 recording resumes");

        // R10: call-stack mode
        write_sel(16'h0200);
        tick();
        for (int i = 0; i < 3; i++) begin
            branch(3'd1, 1'b0, seed++);
            tick();
            check_top("R10 call push");
        end
        branch(3'd3, 1'b0, seed++);
        tick();
        check_top("R10 return pop");
        check_all("R10 after pop");
        while (mtos != 4'd0) begin
            branch(3'd2, 1'b1, seed++);
            tick();
        end
        branch(3'd3, 1'b1, seed++);
        tick();
        check_top("R10 pop wraps");
        check_all("R10 wrap image");

        // R9: no freeze in call-stack mode
        pmi = 1'b1;
        tick();
        chk("R9 no freeze in call-stack", 64'(frozen), 64'd0);
        branch(3'd6, 1'b0, seed++);
        tick();
        check_top("R9 still recording");

        // R11: clear with a branch in the same cycle
        write_sel(16'h0000);
        tick();
        clear = 1'b1;
        branch(3'd0, 1'b0, seed++);
        tick();
        check_all("R11 clear");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule